// File: doc/BRIEF.md
# Programmable Auxiliary Clock Generator

The block turns a fast reference clock into a square-wave auxiliary output, steered by one 8-bit configuration word. The three top bits of the word choose what the output does: it can be a static port bit, a high-frequency divided clock, or one of six low-frequency clocks. The low-frequency clocks differ in their prescale ratio. The five low bits give the programmable divide value N. All stages run on the reference clock through clock enables, so the block creates no derived clocks.

A write to the configuration word restarts every divider stage from zero, in the same cycle that the new value lands. The output then starts a fresh low phase, so software gets a known phase after each write. The terminal-count enable of the fixed divide-by-128 front end leaves the block as a port, so that other tone generators can share it.

Top module: `auxclk_gen`

## Requirements
- R1: After reset the configuration word holds 0x2A, which is high-frequency mode with N=10. `aux_o` is low while reset is held. After reset is released, `aux_o` rises at the 40th clock edge and falls at the 80th.
- R2: Bits [7:5] of the configuration word select the mode and bits [4:0] hold N. Mode 0 is the static port, mode 1 is the high-frequency path, and modes 2 to 7 are the low-frequency paths.
- R3: In mode 0 no clock is generated. `aux_o` equals bit 0 of the word from the write edge on, and it keeps that value until the next write.
- R4: In mode 1 with N≥2, `aux_o` has a period of 8·N reference cycles.
- R5: In mode 1 with N equal to 0 or 1, `aux_o` stays low.
- R6: In mode m from 2 to 7, the output toggles on a tick that comes every 128·P reference cycles, where P = 2^(m+4). This gives P from 64 to 2048. The output period is (32+N) ticks.
- R7: With a total divisor D (N in mode 1, 32+N in modes 2 to 7), `aux_o` is low for ceil(D/2) ticks and then high for floor(D/2) ticks, so the period is exact for odd D.
- R8: A write in any generating mode forces `aux_o` low at the write edge. It also clears the divide-by-8 stage, the divide-by-16 stage, the prescaler and the divider. The first tick of the new setting falls 8 cycles after the write in mode 1, and 128·P cycles after the write in modes 2 to 7.
- R9: `mid_tick_o` pulses high for one cycle every 128 reference cycles. Its first pulse after a write is in the cycle just before the 128th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data: mode [7:5], N [4:0] |
| aux_o | output | 1 | Auxiliary square-wave or static output |
| mid_tick_o | output | 1 | Divide-by-128 terminal-count enable |

## Verification
Every result is counted from the write edge W. In the static mode the output is due right after W. A high-frequency output rises 8·ceil(N/2) edges after W and falls 8·N edges after W. A low-frequency output moves in steps of 128·P cycles, and `mid_tick_o` is high in the cycle before edge W+127+1. The bench writes at a known edge and then samples on the falling edge just before and just after each expected transition, which pins every transition to one exact cycle. The long low-frequency ratios run on a second instance whose front-end widths are reduced, while the default instance confirms the 64× ratio once.

// File: rtl/auxclk_pkg.sv
package auxclk_pkg;
  localparam int CFG_W     = 8;
  localparam int MODE_W    = 3;
  localparam int N_W       = 5;
  localparam int LF_OFFSET = 32;
  localparam int D_W       = $clog2(LF_OFFSET + (1 << N_W));
  localparam logic [CFG_W-1:0] CFG_RST = 8'h2A;

  typedef enum logic [MODE_W-1:0] {
    MODE_PORT = 3'd0,
    MODE_HF   = 3'd1,
    MODE_LF0  = 3'd2
  } mode_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [N_W-1:0]    n;
  } cfg_t;
endpackage

// File: rtl/auxclk_cfg_reg.sv
module auxclk_cfg_reg
  import auxclk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output logic                port_mode_o,
  output logic                hf_mode_o,
  output logic [MODE_W-1:0]   lf_shift_o,
  output logic                port_bit_o,
  output logic [D_W-1:0]      div_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= cfg_t'(CFG_RST);
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  always_comb begin
    port_mode_o = (cfg_q.mode == MODE_PORT);
    hf_mode_o   = (cfg_q.mode == MODE_HF);
    lf_shift_o  = (cfg_q.mode >= MODE_LF0) ? cfg_q.mode - MODE_LF0 : '0;
    port_bit_o  = cfg_q.n[0];
    if (hf_mode_o) div_o = D_W'(cfg_q.n);
    else           div_o = D_W'(LF_OFFSET) + D_W'(cfg_q.n);
  end
endmodule

// File: rtl/auxclk_ctr_stage.sv
module auxclk_ctr_stage #(
  parameter int W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i & (&cnt_q);
endmodule

// File: rtl/auxclk_prescale.sv
module auxclk_prescale #(
  parameter int FAST_W     = 3,
  parameter int MID_W      = 4,
  parameter int PRE_BASE_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [2:0] lf_shift_i,
  output logic       fast_tick_o,
  output logic       mid_tick_o,
  output logic       lf_tick_o
);
  localparam int NSTG  = 2;
  localparam int PRE_W = PRE_BASE_W + 5;
  localparam int STG_W [NSTG] = '{FAST_W, MID_W};

  logic [NSTG:0] tick;
  assign tick[0] = 1'b1;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    auxclk_ctr_stage #(.W(STG_W[s])) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .en_i  (tick[s]),
      .tick_o(tick[s+1])
    );
  end

  assign fast_tick_o = tick[1];
  assign mid_tick_o  = tick[NSTG];

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [PRE_W-1:0] all_ones;
  assign all_ones = '1;
  assign pre_mask = all_ones >> (3'd5 - lf_shift_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_q <= '0;
    else if (clr_i)      pre_q <= '0;
    else if (mid_tick_o) pre_q <= pre_q + 1'b1;
  end

  assign lf_tick_o = mid_tick_o & (&(pre_q | ~pre_mask));

  // R9
  mid_tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_tick_o |=> !mid_tick_o);
  // R8
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fast_tick_o && !lf_tick_o);
endmodule

// File: rtl/auxclk_out_div.sv
module auxclk_out_div
  import auxclk_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           tick_i,
  input  logic [D_W-1:0] div_i,
  output logic           q_o
);
  logic [D_W-1:0] cnt_q, cnt_nx;
  logic [D_W:0]   low_len;
  logic           run;

  assign run     = div_i >= D_W'(2);
  assign low_len = ({1'b0, div_i} + 1'b1) >> 1;
  assign cnt_nx  = (cnt_q == div_i - 1'b1) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (tick_i && run) begin
      cnt_q <= cnt_nx;
      q_o   <= {1'b0, cnt_nx} >= low_len;
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !tick_i |=> $stable(q_o));
  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> cnt_q < div_i);
endmodule

// File: rtl/auxclk_gen.sv
module auxclk_gen
  import auxclk_pkg::*;
#(
  parameter int FAST_W     = 3,
  parameter int MID_W      = 4,
  parameter int PRE_BASE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             aux_o,
  output logic             mid_tick_o
);
  logic              port_mode, hf_mode, port_bit, gen_q;
  logic              fast_tick, lf_tick, sel_tick;
  logic [MODE_W-1:0] lf_shift;
  logic [D_W-1:0]    div;

  auxclk_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .port_mode_o(port_mode),
    .hf_mode_o  (hf_mode),
    .lf_shift_o (lf_shift),
    .port_bit_o (port_bit),
    .div_o      (div)
  );

  auxclk_prescale #(
    .FAST_W    (FAST_W),
    .MID_W     (MID_W),
    .PRE_BASE_W(PRE_BASE_W)
  ) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cfg_we_i),
    .lf_shift_i (lf_shift),
    .fast_tick_o(fast_tick),
    .mid_tick_o (mid_tick_o),
    .lf_tick_o  (lf_tick)
  );

  always_comb begin
    if (port_mode)    sel_tick = 1'b0;
    else if (hf_mode) sel_tick = fast_tick;
    else              sel_tick = lf_tick;
  end

  auxclk_out_div u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cfg_we_i),
    .tick_i(sel_tick),
    .div_i (div),
    .q_o   (gen_q)
  );

  assign aux_o = port_mode ? port_bit : gen_q;

  // R3
  static_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_wdata_i[7:5] == 3'd0) |=> aux_o == $past(cfg_wdata_i[0]));
  // R8
  restart_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && (cfg_wdata_i[7:5] != 3'd0) |=> !aux_o);
  // R5
  hf_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_mode && (div < D_W'(2)) |-> !aux_o);
endmodule

// File: tb/auxclk_gen_tb.sv
`timescale 1ns/1ps
module auxclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_a = 1'b0, we_b = 1'b0;
  logic [7:0] wd_a = '0, wd_b = '0;
  logic       aux_a, tick_a, aux_b, tick_b;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  auxclk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we_a), .cfg_wdata_i(wd_a),
    .aux_o(aux_a), .mid_tick_o(tick_a)
  );

  // reduced front end: fast tick every 2, mid tick every 4 cycles, P = 2^(m-1)
  auxclk_gen #(.FAST_W(1), .MID_W(1), .PRE_BASE_W(1)) dut_lf_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we_b), .cfg_wdata_i(wd_b),
    .aux_o(aux_b), .mid_tick_o(tick_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    if (sel) begin we_b = 1'b1; wd_b = d; end
    else     begin we_a = 1'b1; wd_a = d; end
    @(posedge clk);
    @(negedge clk);
    we_a = 1'b0;
    we_b = 1'b0;
  endtask

  task automatic test_reset();
    step(3);
    check("R1 aux in reset", aux_a, 0);
    rst_n = 1'b1;
    step(39); check("R1 low at edge 39", aux_a, 0);
    step(1);  check("R1 high at edge 40", aux_a, 1);
    step(39); check("R1 high at edge 79", aux_a, 1);
    step(1);  check("R1 low at edge 80", aux_a, 0);
  endtask

  task automatic test_static();
    wr(0, 8'h01); check("R3 static bit 1", aux_a, 1);
    step(100);    check("R3 static hold 1", aux_a, 1);
    wr(0, 8'h1E); check("R2 R3 static bit 0 with N bits", aux_a, 0);
    step(50);     check("R3 static hold 0", aux_a, 0);
    wr(0, 8'h1F); check("R3 static bit 1 again", aux_a, 1);
  endtask

  task automatic test_hf();
    int hi;
    wr(0, 8'h23);  check("R8 low after write", aux_a, 0);
    step(15); check("R4 N3 low W+15", aux_a, 0);
    step(1);  check("R4 R7 N3 rise W+16", aux_a, 1);
    step(7);  check("R7 N3 high W+23", aux_a, 1);
    step(1);  check("R4 N3 fall W+24", aux_a, 0);
    hi = 0;
    for (int i = 0; i < 48; i++) begin step(1); hi += aux_a; end
    check("R7 N3 high count", hi, 16);
    wr(0, 8'h24);
    step(15); check("R4 N4 low W+15", aux_a, 0);
    step(1);  check("R4 N4 rise W+16", aux_a, 1);
    step(15); check("R4 N4 high W+31", aux_a, 1);
    step(1);  check("R4 N4 fall W+32", aux_a, 0);
  endtask

  task automatic test_hf_idle();
    int hi;
    wr(0, 8'h20); hi = 0;
    for (int i = 0; i < 200; i++) begin step(1); hi += aux_a; end
    check("R5 N0 stays low", hi, 0);
    wr(0, 8'h21); hi = 0;
    for (int i = 0; i < 200; i++) begin step(1); hi += aux_a; end
    check("R5 N1 stays low", hi, 0);
  endtask

  task automatic test_restart();
    wr(0, 8'h23);
    step(18); check("R8 pre-restart high", aux_a, 1);
    wr(0, 8'h23); check("R8 forced low on rewrite", aux_a, 0);
    step(15); check("R8 phase restarts W+15", aux_a, 0);
    step(1);  check("R8 phase restarts W+16", aux_a, 1);
    wr(0, 8'h40); check("R8 mode change forces low", aux_a, 0);
  endtask

  task automatic test_mid_tick();
    wr(0, 8'h23);
    step(126); check("R9 no tick W+126", tick_a, 0);
    step(1);   check("R9 tick before W+128", tick_a, 1);
    step(1);   check("R9 single cycle tick", tick_a, 0);
    step(126); check("R9 no tick W+254", tick_a, 0);
    step(1);   check("R9 second tick", tick_a, 1);
  endtask

  task automatic test_lf_small();
    wr(1, 8'h40);
    step(127); check("R6 m2 N0 low W+127", aux_b, 0);
    step(1);   check("R6 m2 N0 rise W+128", aux_b, 1);
    step(127); check("R6 m2 N0 high W+255", aux_b, 1);
    step(1);   check("R6 m2 N0 fall W+256", aux_b, 0);
    wr(1, 8'hA1);
    step(1087); check("R6 m5 N1 low W+1087", aux_b, 0);
    step(1);    check("R6 R7 m5 N1 rise W+1088", aux_b, 1);
    step(1023); check("R7 m5 N1 high W+2111", aux_b, 1);
    step(1);    check("R6 m5 N1 fall W+2112", aux_b, 0);
    wr(1, 8'hFF);
    step(8191); check("R6 m7 N31 low W+8191", aux_b, 0);
    step(1);    check("R6 m7 N31 rise W+8192", aux_b, 1);
    step(7935); check("R7 m7 N31 high W+16127", aux_b, 1);
    step(1);    check("R6 R7 m7 N31 fall W+16128", aux_b, 0);
  endtask

  task automatic test_lf_full();
    wr(0, 8'h40);
    step(131071); check("R6 P64 low W+131071", aux_a, 0);
    step(1);      check("R6 P64 rise W+131072", aux_a, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_static();
    test_hf();
    test_hf_idle();
    test_restart();
    test_mid_tick();
    test_lf_small();
    test_lf_full();
    finish_run();
  end
endmodule